// File: doc/BRIEF.md
# Two-Wire Serial Word-Memory Slave

This block is a slave on a two-wire serial bus (START/STOP framing, eight data bits plus an acknowledge clock per byte). It lets a bus master reach a memory of 32 rows of 16 bits, kept as a register array. SCL and SDA are sampled on the system clock. All bus events are then found from the sampled levels. The slave has no device address byte. The first byte after a START is a control byte. It names the row, the byte order and the direction of the access.

A write loads the addressed row into a 16-bit buffer. The master then overwrites one or both bytes of the buffer, and the STOP commits the buffer back to the row. After the commit the slave runs a programming period, during which it acknowledges no control byte. The master polls until it gets an acknowledge. A read streams buffer bytes in the chosen order. Each time a full word has gone out, the row steps up or down and wraps at the ends. A small set of control bytes is not a memory access: these are passed to neighbouring logic as special commands.

SDA is driven open-drain style. The output `sda_oe_o` high pulls the line low.

Top module: `twowire_word_slave`

## Requirements
- R1: The control byte carries the row in bits 7..3, the mode in bits 2..1 and the direction in bit 0 (0 = write, 1 = read). Mode 01 selects low byte first with row increment. Mode 10 selects high byte first with row decrement.
- R2: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A START in any state begins reception of a new control byte. A STOP returns the slave to idle with SDA released.
- R3: For every byte it accepts, the slave drives SDA low for the whole of the ninth clock. At all other times outside its own data bits it leaves SDA released.
- R4: A write loads the addressed row into the buffer. One or two data bytes then overwrite the buffer in mode order, and a STOP after at least one data byte stores the buffer into the row. A STOP right after the control byte stores nothing. A third data byte is not acknowledged and not stored.
- R5: A START that arrives before the STOP of a write discards that write.
- R6: A committed write makes the slave busy for PROG_CYCLES system clocks. While busy, it answers every control byte with no acknowledge. Once the period is over, control bytes are acknowledged again.
- R7: A read sends bytes MSB first in mode order. After the master acknowledges the second byte of a word, the row steps by one (up for mode 01, down for mode 10), wrapping from 31 to 0 and from 0 to 31, and the next word follows.
- R8: When the master does not acknowledge a sent byte, the slave releases SDA and sends nothing more until the next START or STOP.
- R9: A control byte of the form 11xxx111 is acknowledged and does not touch the memory. It pulses `spec_strobe_o` for one cycle with the byte on `spec_cmd_o`. It holds `spec_active_o` high until the next START or STOP. In this mode further bytes are not acknowledged.
- R10: Any other control byte (mode 00 or 11 that is not a special command, including the reserved pattern xxxxx110) gets no acknowledge and has no effect on the memory.
- R11: After reset, SDA is released, all rows read zero, the slave is not busy, and `spec_active_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe_o | output | 1 | High pulls SDA low |
| spec_cmd_o | output | 8 | Last special command byte |
| spec_strobe_o | output | 1 | One-cycle pulse when a special command is accepted |
| spec_active_o | output | 1 | Special mode in force until next START or STOP |

## Verification
The hardest state to reach from the ports is the row wrap during a streamed read. Reaching it needs a master that keeps acknowledging through a word boundary that starts at row 31 (increment) or row 0 (decrement). It also needs known contents in both rows. Directed writes first fill rows 31 and 0. Reads of four bytes then cross each end in both directions. The busy window is also reached directly: every committed write is followed at once by control-byte polls. The first poll must be refused, and a later poll must be accepted. Random writes and reads of varied length, row and order then run against a bench-side copy of the memory.

// File: rtl/tws_pkg.sv
// Shared types for the two-wire word-memory slave.
package tws_pkg;

    // Protocol engine states.
    typedef enum logic [3:0] {
        ST_IDLE,     // standby, waiting for START
        ST_CTRL,     // shifting in the control byte
        ST_ACK,      // ninth clock of a received byte
        ST_WDATA,    // shifting in a write data byte
        ST_TX,       // shifting out a read data byte
        ST_MACK,     // ninth clock of a sent byte, master answers
        ST_IGNORE,   // refused or finished, wait for START/STOP
        ST_SPECIAL   // special command in force, bus lines left to others
    } tws_state_e;

    // Byte-order / direction modes carried in the control byte.
    localparam logic [1:0] MODE_LO_INC = 2'b01;
    localparam logic [1:0] MODE_HI_DEC = 2'b10;

    // True for control bytes of the form 11xxx111.
    function automatic logic is_special_cmd(input logic [7:0] b);
        return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
    endfunction

endpackage

// File: rtl/tws_line_sync.sv
// Oversamples SCL and SDA through a synchronizer chain and reports clock
// edges and START/STOP events. Assumes the bus changes slower than a few
// system clocks, and that STAGES is at least 2. Idle lines reset high.
module tws_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_s, sda_s, scl_p, sda_p;

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    // Synchronizer chains plus one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    // Event decode from the synchronized levels.
    always_comb begin
        sda_o      = sda_s;
        scl_rise_o = scl_s & ~scl_p;
        scl_fall_o = ~scl_s & scl_p;
        start_o    = scl_s & scl_p & sda_p & ~sda_s;
        stop_o     = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/tws_word_store.sv
// Register-array word memory with one synchronous write port and one
// combinational read port. Cleared to zero by reset.
module tws_word_store #(
    parameter int ROW_W  = 5,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ROW_W-1:0]  waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ROW_W-1:0]  raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int ROWS = 1 << ROW_W;

    logic [WORD_W-1:0] mem_q [ROWS];

    // Reset clears every row; a write updates one row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Asynchronous read of the selected row.
    assign rdata_o = mem_q[raddr_i];

    AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)) else $error("store write lost"); // R4

endmodule

// File: rtl/tws_busy_timer.sv
// Programming-period timer. A start pulse loads the cycle count; busy stays
// high until the count has run down. Assumes CYCLES is at least 1.
module tws_busy_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start_i)      cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o) else $error("busy not raised"); // R6
    AST_BUSY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("busy count skipped"); // R6

endmodule

// File: rtl/twowire_word_slave.sv
// Two-wire serial slave giving a master access to a 32 x 16-bit memory.
// The first byte after START is a control byte: row, byte-order mode and
// direction. Writes go through a read-modify-write word buffer committed at
// STOP; reads stream words with row step and wrap. Assumes SCL phases last
// several system clocks and that a word is exactly two bytes.
module twowire_word_slave #(
    parameter int ROW_W       = 5,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PROG_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] spec_cmd_o,
    output logic              spec_strobe_o,
    output logic              spec_active_o
);
    import tws_pkg::*;

    localparam int WORD_W = 2 * BYTE_W;
    localparam int BIT_W  = $clog2(BYTE_W + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [BIT_W-1:0] ALL_BITS = BIT_W'(BYTE_W);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy;
    logic store_we;
    logic [ROW_W-1:0]  rd_addr;
    logic [WORD_W-1:0] rd_data;

    tws_state_e        state_q, nxt_q;
    logic [BIT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] sr_q, tx_sr_q;
    logic              ack_q, ack_drv_q, oe_q;
    logic [ROW_W-1:0]  row_q;
    logic              hi_first_q, byte_idx_q, pend_q;
    logic [1:0]        wcount_q;
    logic [WORD_W-1:0] buf_q;
    logic [BYTE_W-1:0] spec_cmd_q;
    logic              spec_strobe_q, spec_act_q;

    logic [BYTE_W-1:0] rx_full;
    logic [ROW_W-1:0]  c_row, row_step;
    logic [1:0]        c_mode;
    logic              c_rd, c_mem, c_special;
    logic              sel_hi, wsel_hi;
    logic [BYTE_W-1:0] cur_byte;

    tws_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    tws_word_store #(.ROW_W(ROW_W), .WORD_W(WORD_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (store_we),
        .waddr_i (row_q),
        .wdata_i (buf_q),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    tws_busy_timer #(.CYCLES(PROG_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (store_we),
        .busy_o  (busy)
    );

    // Control-byte field decode from the byte completing on this SCL rise.
    always_comb begin
        rx_full   = {sr_q[BYTE_W-2:0], sda_s};
        c_row     = rx_full[BYTE_W-1 -: ROW_W];
        c_mode    = rx_full[2:1];
        c_rd      = rx_full[0];
        c_special = is_special_cmd(rx_full);
        c_mem     = (c_mode == MODE_LO_INC) || (c_mode == MODE_HI_DEC);
    end

    // Row stepping, read address and buffer byte selection.
    always_comb begin
        row_step = hi_first_q ? (row_q - 1'b1) : (row_q + 1'b1);
        rd_addr  = (state_q == ST_CTRL) ? c_row : row_step;
        sel_hi   = hi_first_q ^ byte_idx_q;
        wsel_hi  = hi_first_q ^ wcount_q[0];
        cur_byte = sel_hi ? buf_q[WORD_W-1 -: BYTE_W] : buf_q[BYTE_W-1:0];
    end

    // Commit the buffer when a STOP closes a write that carried data.
    assign store_we = stop_det && pend_q;

    // Protocol engine: byte shifting, acknowledge, buffer and row handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            nxt_q         <= ST_IDLE;
            bit_cnt_q     <= '0;
            sr_q          <= '0;
            tx_sr_q       <= '0;
            ack_q         <= 1'b0;
            ack_drv_q     <= 1'b0;
            oe_q          <= 1'b0;
            row_q         <= '0;
            hi_first_q    <= 1'b0;
            byte_idx_q    <= 1'b0;
            pend_q        <= 1'b0;
            wcount_q      <= '0;
            buf_q         <= '0;
            spec_cmd_q    <= '0;
            spec_strobe_q <= 1'b0;
            spec_act_q    <= 1'b0;
        end else begin
            spec_strobe_q <= 1'b0;
            if (start_det) begin
                state_q    <= ST_CTRL;
                bit_cnt_q  <= '0;
                ack_drv_q  <= 1'b0;
                oe_q       <= 1'b0;
                pend_q     <= 1'b0;
                spec_act_q <= 1'b0;
            end else if (stop_det) begin
                state_q    <= ST_IDLE;
                ack_drv_q  <= 1'b0;
                oe_q       <= 1'b0;
                pend_q     <= 1'b0;
                spec_act_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_CTRL: begin
                        if (scl_rise) begin
                            sr_q      <= rx_full;
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (bit_cnt_q == LAST_BIT) begin
                                bit_cnt_q <= '0;
                                state_q   <= ST_ACK;
                                if (busy) begin
                                    ack_q <= 1'b0;
                                    nxt_q <= ST_IGNORE;
                                end else if (c_special) begin
                                    ack_q         <= 1'b1;
                                    nxt_q         <= ST_SPECIAL;
                                    spec_cmd_q    <= rx_full;
                                    spec_strobe_q <= 1'b1;
                                    spec_act_q    <= 1'b1;
                                end else if (c_mem) begin
                                    ack_q      <= 1'b1;
                                    row_q      <= c_row;
                                    hi_first_q <= (c_mode == MODE_HI_DEC);
                                    byte_idx_q <= 1'b0;
                                    wcount_q   <= '0;
                                    buf_q      <= rd_data;
                                    nxt_q      <= c_rd ? ST_TX : ST_WDATA;
                                end else begin
                                    ack_q <= 1'b0;
                                    nxt_q <= ST_IGNORE;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_drv_q) begin
                                oe_q      <= ack_q;
                                ack_drv_q <= 1'b1;
                            end else begin
                                ack_drv_q <= 1'b0;
                                state_q   <= nxt_q;
                                bit_cnt_q <= '0;
                                if (nxt_q == ST_TX) begin
                                    tx_sr_q <= cur_byte;
                                    oe_q    <= ~cur_byte[BYTE_W-1];
                                end else begin
                                    oe_q <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            sr_q      <= rx_full;
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (bit_cnt_q == LAST_BIT) begin
                                bit_cnt_q <= '0;
                                state_q   <= ST_ACK;
                                if (wcount_q < 2'd2) begin
                                    if (wsel_hi) buf_q[WORD_W-1 -: BYTE_W] <= rx_full;
                                    else         buf_q[BYTE_W-1:0]         <= rx_full;
                                    wcount_q <= wcount_q + 1'b1;
                                    pend_q   <= 1'b1;
                                    ack_q    <= 1'b1;
                                    nxt_q    <= ST_WDATA;
                                end else begin
                                    ack_q <= 1'b0;
                                    nxt_q <= ST_IGNORE;
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt_q == ALL_BITS) begin
                                oe_q    <= 1'b0;
                                state_q <= ST_MACK;
                            end else begin
                                tx_sr_q <= tx_sr_q << 1;
                                oe_q    <= ~tx_sr_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (sda_s) begin
                                state_q <= ST_IGNORE;
                            end else if (byte_idx_q) begin
                                row_q      <= row_step;
                                buf_q      <= rd_data;
                                byte_idx_q <= 1'b0;
                            end else begin
                                byte_idx_q <= 1'b1;
                            end
                        end else if (scl_fall) begin
                            tx_sr_q   <= cur_byte;
                            oe_q      <= ~cur_byte[BYTE_W-1];
                            bit_cnt_q <= '0;
                            state_q   <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o      = oe_q;
    assign spec_cmd_o    = spec_cmd_q;
    assign spec_strobe_o = spec_strobe_q;
    assign spec_active_o = spec_act_q;

    AST_OE_ONLY_WHEN_TALKING: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (state_q == ST_ACK || state_q == ST_TX)) else $error("SDA driven out of turn"); // R3
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe_o && state_q == ST_IDLE)) else $error("STOP not honoured"); // R2
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CTRL && scl_rise && bit_cnt_q == LAST_BIT && busy && !start_det && !stop_det)
        |=> !ack_q) else $error("acknowledge while busy"); // R6
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MACK && scl_rise && !sda_s && byte_idx_q && !start_det && !stop_det)
        |=> row_q == ($past(hi_first_q) ? ROW_W'($past(row_q) - 1'b1) : ROW_W'($past(row_q) + 1'b1)))
        else $error("row step wrong"); // R7
    AST_SPECIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_active_o && state_q == ST_SPECIAL) |-> (!sda_oe_o && !store_we)) else $error("special mode not quiet"); // R9

endmodule

// File: tb/twowire_word_slave_tb_top.sv
module twowire_word_slave_tb_top;
    localparam int H    = 6;
    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [7:0] spec_cmd;
    logic spec_strobe, spec_active;

    int checks = 0;
    int errors = 0;
    int spec_cnt = 0;
    logic [7:0] spec_last = '0;
    logic [15:0] mem_m [32];

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    twowire_word_slave #(.PROG_CYCLES(PROG)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .sda_oe_o      (sda_oe),
        .spec_cmd_o    (spec_cmd),
        .spec_strobe_o (spec_strobe),
        .spec_active_o (spec_active)
    );

    always @(posedge clk) begin
        if (rst_n && spec_strobe) begin
            spec_cnt  <= spec_cnt + 1;
            spec_last <= spec_cmd;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bstart();
        sda_m = 1'b1; tick(2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(2);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic pulse(output logic s);
        tick(H);
        scl_m = 1'b1; tick(H / 2);
        s = sda_line; tick(H / 2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            pulse(s);
        end
        sda_m = 1'b1;
        pulse(s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            pulse(s);
            b = {b[6:0], s};
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        pulse(s);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] ctrl_byte(input logic [4:0] row, input logic hi, input logic rd);
        return {row, hi ? 2'b10 : 2'b01, rd};
    endfunction

    function automatic logic [7:0] exp_byte(input logic [4:0] row, input logic hi, input int k);
        logic [4:0] r;
        logic [15:0] w;
        r = hi ? row - 5'(k / 2) : row + 5'(k / 2);
        w = mem_m[r];
        return (hi ^ k[0]) ? w[15:8] : w[7:0];
    endfunction

    // Poll with write control bytes until acknowledged; returns refusals.
    task automatic wait_ready(output int refusals);
        logic a;
        refusals = 0;
        for (int p = 0; p < 40; p++) begin
            bstart();
            send_byte(ctrl_byte(5'd0, 1'b0, 1'b0), a);
            bstop();
            if (a) break;
            refusals++;
        end
    endtask

    task automatic do_write(input logic [4:0] row, input logic hi, input int n,
                            input logic [7:0] b0, input logic [7:0] b1);
        logic a;
        logic [15:0] w;
        int refusals;
        w = mem_m[row];
        bstart();
        send_byte(ctrl_byte(row, hi, 1'b0), a);
        chk(a, "R1 write control acknowledged", a, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = (k == 0) ? b0 : b1;
            send_byte(d, a);
            chk(a, "R3 write data acknowledged", a, 1);
            if (hi ^ k[0]) w[15:8] = d; else w[7:0] = d;
        end
        bstop();
        if (n > 0) begin
            mem_m[row] = w;
            wait_ready(refusals);
            chk(refusals > 0, "R6 poll refused right after commit", refusals, 1);
            chk(refusals < 40, "R6 poll accepted after programming", refusals, 0);
        end
    endtask

    task automatic do_read(input logic [4:0] row, input logic hi, input int n);
        logic a, s;
        logic [7:0] b;
        bstart();
        send_byte(ctrl_byte(row, hi, 1'b1), a);
        chk(a, "R1 read control acknowledged", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(b == exp_byte(row, hi, k), "R7 read byte", b, exp_byte(row, hi, k));
        end
        sda_m = 1'b1;
        pulse(s);
        chk(s == 1'b1 && sda_oe == 1'b0, "R8 released after master no-ack", s, 1);
        bstop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        int refusals;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) mem_m[i] = '0;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R11 reset state
        chk(sda_oe == 1'b0, "R11 SDA released after reset", sda_oe, 0);
        chk(spec_active == 1'b0, "R11 special inactive after reset", spec_active, 0);
        do_read(5'd0, 1'b0, 2);
        do_read(5'd31, 1'b1, 2);
        wait_ready(refusals);
        chk(refusals == 0, "R11 not busy after reset", refusals, 0);

        // R7 wrap in both directions
        do_write(5'd31, 1'b0, 2, 8'h34, 8'h12);
        do_write(5'd0, 1'b1, 2, 8'hAB, 8'hCD);
        do_read(5'd31, 1'b0, 4);
        do_read(5'd0, 1'b1, 4);

        // R4 control byte only stores nothing and starts no programming
        bstart();
        send_byte(ctrl_byte(5'd3, 1'b0, 1'b0), a);
        bstop();
        wait_ready(refusals);
        chk(refusals == 0, "R4 control-only write starts no programming", refusals, 0);
        do_read(5'd3, 1'b0, 2);

        // R4 single byte keeps the other half of the word
        do_write(5'd4, 1'b0, 2, 8'h11, 8'h22);
        do_write(5'd4, 1'b1, 1, 8'h99, 8'h00);
        do_read(5'd4, 1'b0, 2);

        // R4 third data byte refused and not stored
        bstart();
        send_byte(ctrl_byte(5'd5, 1'b0, 1'b0), a);
        send_byte(8'h5A, a);
        send_byte(8'hA5, a);
        send_byte(8'hFF, a);
        chk(!a, "R4 third data byte not acknowledged", a, 0);
        bstop();
        mem_m[5] = 16'hA55A;
        wait_ready(refusals);
        do_read(5'd5, 1'b0, 2);

        // R5 repeated START discards a pending write
        bstart();
        send_byte(ctrl_byte(5'd6, 1'b0, 1'b0), a);
        send_byte(8'hEE, a);
        bstart();
        bstop();
        wait_ready(refusals);
        chk(refusals == 0, "R5 discarded write starts no programming", refusals, 0);
        do_read(5'd6, 1'b0, 2);

        // R9 special command
        bstart();
        send_byte(8'hCF, a);
        chk(a, "R9 special command acknowledged", a, 1);
        tick(2);
        chk(spec_cnt == 1, "R9 one strobe", spec_cnt, 1);
        chk(spec_last == 8'hCF, "R9 command byte passed on", spec_last, 8'hCF);
        chk(spec_active == 1'b1, "R9 special mode active", spec_active, 1);
        send_byte(8'h55, a);
        chk(!a, "R9 no acknowledge in special mode", a, 0);
        bstop();
        tick(2);
        chk(spec_active == 1'b0, "R9 STOP ends special mode", spec_active, 0);
        do_read(5'd25, 1'b0, 2);

        // R10 reserved and undefined mode control bytes
        bstart();
        send_byte({5'd9, 2'b11, 1'b0}, a);
        chk(!a, "R10 reserved control refused", a, 0);
        bstart();
        send_byte({5'd10, 2'b00, 1'b1}, a);
        chk(!a, "R10 mode 00 refused", a, 0);
        // R2 START after a refusal begins a fresh control byte
        bstart();
        send_byte(ctrl_byte(5'd9, 1'b0, 1'b0), a);
        chk(a, "R2 START restarts control reception", a, 1);
        bstop();
        tick(2);
        chk(sda_oe == 1'b0, "R2 SDA released at idle", sda_oe, 0);
        do_read(5'd9, 1'b0, 2);

        // random mix
        for (int it = 0; it < 24; it++) begin
            logic [4:0] row;
            logic hi;
            row = 5'($urandom % 32);
            hi  = 1'($urandom % 2);
            if ($urandom % 2 == 0)
                do_write(row, hi, 1 + int'($urandom % 2), 8'($urandom), 8'($urandom));
            else
                do_read(row, hi, 1 + int'($urandom % 6));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule